// File: doc/BRIEF.md
# Arbitrating Serial Frame Transmitter for a Two-Level Wired-AND Bus

This block is the sending half of a node on a multi-drop bus on which a 0 driven by any node pulls the whole line to 0. The 0 level is dominant and the 1 level is recessive. After one `start` pulse, the block takes an 11-bit identifier, a 4-bit length code and up to eight payload bytes. It then emits one standard-format data frame, one bit for each pulse of `bit_en`. That strobe comes from an external bit-time prescaler. The frame carries a 15-bit checksum. Bit stuffing guarantees that the line changes level often enough for receivers to stay in step.

While the identifier and the remote-request bit go out, the block compares every bit it sends with the line level it reads back on `rx_bit`. Suppose it sent a recessive bit but the line was dominant. Another node with a numerically lower identifier has then claimed the bus. The block releases the line at once and reports `arb_lost`. The winner's frame is left untouched. To retry, the user issues `start` again. A mismatch after the arbitration bits does not count as lost arbitration, so the frame runs to its end.

Top module: `can_arb_tx`

## Requirements
- R1: After reset, `tx_bit` is 1 and `busy`, `arb_lost` and `done` are 0.
- R2: While `busy` is 0, a `start` pulse captures `id`, `dlc` and `data` and raises `busy` on the next clock. While `busy` is 1, `start` and any change to `id`, `dlc` or `data` have no effect on the frame being sent.
- R3: Each `bit_en` pulse while busy puts the next frame bit on `tx_bit`, and `tx_bit` holds its value between pulses. Without stuffing, the frame bits go out in this order:
  - one 0 start bit;
  - the identifier, most significant bit first;
  - three 0 bits for remote-request, format and reserved;
  - the 4-bit length code, most significant bit first;
  - the payload, byte 0 (`data[7:0]`) first, each byte most significant bit first.
- R4: The payload holds min(`dlc`, 8) bytes. The length field carries the raw `dlc` value, even when it is above 8.
- R5: After the payload come 15 checksum bits, most significant first. The checksum is the remainder of polynomial 0x4599, computed over the start bit through the last payload bit with the register starting at 0. Each step computes f = bit XOR reg[14], shifts the register left by one, and XORs in 0x4599 when f is 1.
- R6: From the start bit through the last checksum bit, after every run of five equal consecutive bits (stuff bits included) one bit of the opposite value is inserted. This also applies when the run ends on the last checksum bit.
- R7: After the checksum come ten recessive bits: the checksum delimiter, the acknowledge slot, the acknowledge delimiter and seven end-of-frame bits. The block sends these bits whatever the line reads.
- R8: Consider a `bit_en` pulse that ends an identifier or remote-request bit (not a stuff bit). If at that pulse `tx_bit` is 1 and `rx_bit` is 0, the block does three things on the same clock: `busy` falls, `arb_lost` rises, and `tx_bit` stays 1. `arb_lost` then holds until the next accepted `start`.
- R9: A difference between `tx_bit` and `rx_bit` in any other bit leaves `arb_lost` at 0, and the frame finishes unchanged. This covers stuff bits, the control fields, the payload, the checksum and the acknowledge slot.
- R10: The `bit_en` pulse that ends the last end-of-frame bit raises `done` for exactly one clock and drops `busy` on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-clock strobe marking each bit boundary |
| start | input | 1 | Frame request, accepted only while idle |
| id | input | 11 | Frame identifier |
| dlc | input | 4 | Length code |
| data | input | 64 | Payload, byte k in bits 8k+7..8k |
| rx_bit | input | 1 | Level read back from the bus |
| tx_bit | output | 1 | Level driven onto the bus, 1 = recessive |
| busy | output | 1 | Frame in progress |
| arb_lost | output | 1 | Previous attempt withdrew in arbitration |
| done | output | 1 | One-clock pulse when a frame has been sent in full |

## Verification
The bench concentrates on these corner cases:
- An all-zero identifier and payload, which forces long stuffing chains. An off-by-one in the run counter would shift every later bit.
- Length codes above 8. A design that did not clamp them would send too many payload bytes.
- Competing frames whose identifiers differ only in a late bit. A comparison that also looked at stuff bits or the payload would withdraw wrongly when two nodes share an identifier.
- An acknowledge pulled dominant, and a `start` re-issued in mid-frame. A design that reacted to either would corrupt or truncate its own frame.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

    localparam int ID_W_D       = 11;
    localparam int DLC_W_D      = 4;
    localparam int MAX_BYTES_D  = 8;
    localparam int CRC_W_D      = 15;
    localparam int STUFF_RUN_D  = 5;
    localparam int EOF_LEN_D    = 7;
    localparam logic [CRC_W_D-1:0] CRC_POLY_D = 15'h4599;

    // fixed recessive bits ahead of end-of-frame: checksum delimiter, ack slot, ack delimiter
    localparam int TAIL_FIX = 3;
    // fixed dominant bits between identifier and length code
    localparam int CTRL_FIX = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_CRC,
        PH_TAIL,
        PH_END
    } phase_e;

    // description of the next unstuffed frame bit
    typedef struct packed {
        logic val;
        logic arb;
        logic crc_feed;
        logic crc_out;
        logic stuffable;
        logic fin;
    } fbit_t;

    typedef enum logic [2:0] {
        EM_NONE,
        EM_LOST,
        EM_DONE,
        EM_STUFF,
        EM_FRAME
    } emit_e;

endpackage

// File: rtl/can_tx_crc.sv
module can_tx_crc #(
    parameter int W = can_tx_pkg::CRC_W_D,
    parameter logic [W-1:0] POLY = W'(can_tx_pkg::CRC_POLY_D)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic feed,
    input  logic shift,
    input  logic din,
    output logic msb
);
    logic [W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rem_q <= '0;
        end else if (feed) begin
            rem_q <= {rem_q[W-2:0], 1'b0} ^ ((din ^ rem_q[W-1]) ? POLY : '0);
        end else if (shift) begin
            rem_q <= {rem_q[W-2:0], 1'b0};
        end
    end

    assign msb = rem_q[W-1];
endmodule

// File: rtl/can_tx_stuff.sv
module can_tx_stuff #(
    parameter int RUN = can_tx_pkg::STUFF_RUN_D
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  logic din,
    input  logic span,
    output logic need,
    output logic fill
);
    localparam int RW = $clog2(RUN + 1);

    logic [RW-1:0] run_q;
    logic          last_q;
    logic          span_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q  <= '0;
            last_q <= 1'b1;
            span_q <= 1'b0;
        end else if (step) begin
            last_q <= din;
            span_q <= span;
            if (din != last_q) begin
                run_q <= RW'(1);
            end else if (run_q != RW'(RUN)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign need = span_q && (run_q == RW'(RUN));
    assign fill = ~last_q;
endmodule

// File: rtl/can_tx_fieldseq.sv
module can_tx_fieldseq
    import can_tx_pkg::*;
#(
    parameter int ID_W      = ID_W_D,
    parameter int DLC_W     = DLC_W_D,
    parameter int MAX_BYTES = MAX_BYTES_D,
    parameter int CRC_W     = CRC_W_D,
    parameter int EOF_LEN   = EOF_LEN_D
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   advance,
    input  logic [ID_W-1:0]        id,
    input  logic [DLC_W-1:0]       dlc,
    input  logic [8*MAX_BYTES-1:0] data,
    input  logic                   crc_msb,
    output fbit_t                  nxt
);
    localparam int DATA_W   = 8 * MAX_BYTES;
    localparam int HDR_FIX  = 1 + ID_W + CTRL_FIX + DLC_W;
    localparam int HDR_W    = HDR_FIX + DATA_W;
    localparam int TAIL_LEN = TAIL_FIX + EOF_LEN;
    localparam int CNT_W    = $clog2(HDR_W + CRC_W + TAIL_LEN + 1);

    logic [HDR_W-1:0]  hdr_sr;
    logic [DATA_W-1:0] data_ord;
    logic [DLC_W-1:0]  dlc_eff;
    logic [CNT_W-1:0]  hdr_len;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  plen;
    logic [CNT_W-1:0]  k_q;
    phase_e            ph_q;
    phase_e            ph_next;

    // byte 0 goes out first, so it sits at the top of the shift register
    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_order
        assign data_ord[DATA_W-1-8*b -: 8] = data[8*b +: 8];
    end

    assign dlc_eff = (dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc;
    assign hdr_len = CNT_W'(HDR_FIX) + CNT_W'({dlc_eff, 3'b000});

    always_comb begin
        unique case (ph_q)
            PH_HDR:  begin plen = len_q;            ph_next = PH_CRC;  end
            PH_CRC:  begin plen = CNT_W'(CRC_W);    ph_next = PH_TAIL; end
            PH_TAIL: begin plen = CNT_W'(TAIL_LEN); ph_next = PH_END;  end
            default: begin plen = '1;               ph_next = ph_q;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            k_q    <= '0;
            len_q  <= '0;
            hdr_sr <= '0;
        end else if (load) begin
            ph_q   <= PH_HDR;
            k_q    <= '0;
            len_q  <= hdr_len;
            hdr_sr <= {1'b0, id, CTRL_FIX'(0), dlc, data_ord};
        end else if (advance) begin
            hdr_sr <= hdr_sr << 1;
            if (k_q == plen - 1'b1) begin
                k_q  <= '0;
                ph_q <= ph_next;
            end else begin
                k_q <= k_q + 1'b1;
            end
        end
    end

    always_comb begin
        nxt = '0;
        unique case (ph_q)
            PH_HDR:  nxt.val = hdr_sr[HDR_W-1];
            PH_CRC:  nxt.val = crc_msb;
            default: nxt.val = 1'b1;
        endcase
        nxt.arb       = (ph_q == PH_HDR) && (k_q != '0) && (k_q <= CNT_W'(ID_W + 1));
        nxt.crc_feed  = (ph_q == PH_HDR);
        nxt.crc_out   = (ph_q == PH_CRC);
        nxt.stuffable = (ph_q == PH_HDR) || (ph_q == PH_CRC);
        nxt.fin       = (ph_q == PH_END);
    end
endmodule

// File: rtl/can_arb_tx.sv
module can_arb_tx
    import can_tx_pkg::*;
#(
    parameter int ID_W      = ID_W_D,
    parameter int DLC_W     = DLC_W_D,
    parameter int MAX_BYTES = MAX_BYTES_D,
    parameter int CRC_W     = CRC_W_D,
    parameter int STUFF_RUN = STUFF_RUN_D,
    parameter int EOF_LEN   = EOF_LEN_D
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bit_en,
    input  logic                   start,
    input  logic [ID_W-1:0]        id,
    input  logic [DLC_W-1:0]       dlc,
    input  logic [8*MAX_BYTES-1:0] data,
    input  logic                   rx_bit,
    output logic                   tx_bit,
    output logic                   busy,
    output logic                   arb_lost,
    output logic                   done
);
    fbit_t nb;
    emit_e em;
    logic  go;
    logic  need_stuff;
    logic  stuff_val;
    logic  crc_msb;
    logic  cur_arb_q;
    logic  ebit;

    assign go = start && !busy;

    always_comb begin
        if (!busy || !bit_en)                       em = EM_NONE;
        else if (cur_arb_q && tx_bit && !rx_bit)    em = EM_LOST;
        else if (nb.fin)                            em = EM_DONE;
        else if (need_stuff)                        em = EM_STUFF;
        else                                        em = EM_FRAME;
    end

    assign ebit = (em == EM_STUFF) ? stuff_val : nb.val;

    can_tx_fieldseq #(
        .ID_W(ID_W), .DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES),
        .CRC_W(CRC_W), .EOF_LEN(EOF_LEN)
    ) u_seq (
        .clk(clk), .rst(rst), .load(go), .advance(em == EM_FRAME),
        .id(id), .dlc(dlc), .data(data), .crc_msb(crc_msb), .nxt(nb)
    );

    can_tx_crc #(.W(CRC_W)) u_crc (
        .clk(clk), .rst(rst), .clear(go),
        .feed((em == EM_FRAME) && nb.crc_feed),
        .shift((em == EM_FRAME) && nb.crc_out),
        .din(nb.val), .msb(crc_msb)
    );

    can_tx_stuff #(.RUN(STUFF_RUN)) u_stuff (
        .clk(clk), .rst(rst), .clear(go),
        .step((em == EM_STUFF) || (em == EM_FRAME)),
        .din(ebit),
        .span((em == EM_STUFF) || nb.stuffable),
        .need(need_stuff), .fill(stuff_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_bit    <= 1'b1;
            busy      <= 1'b0;
            arb_lost  <= 1'b0;
            done      <= 1'b0;
            cur_arb_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy      <= 1'b1;
                arb_lost  <= 1'b0;
                cur_arb_q <= 1'b0;
            end
            unique case (em)
                EM_LOST: begin
                    busy      <= 1'b0;
                    arb_lost  <= 1'b1;
                    tx_bit    <= 1'b1;
                    cur_arb_q <= 1'b0;
                end
                EM_DONE: begin
                    busy      <= 1'b0;
                    done      <= 1'b1;
                    tx_bit    <= 1'b1;
                    cur_arb_q <= 1'b0;
                end
                EM_STUFF: begin
                    tx_bit    <= stuff_val;
                    cur_arb_q <= 1'b0;
                end
                EM_FRAME: begin
                    tx_bit    <= nb.val;
                    cur_arb_q <= nb.arb;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/can_arb_tx_chk.sv
module can_arb_tx_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic start,
    input logic rx_bit,
    input logic tx_bit,
    input logic busy,
    input logic arb_lost,
    input logic done
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst) !bit_en |=> $stable(tx_bit)); // R3
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy) && $past(bit_en))); // R10
    AST_LOST_RELEASE: assert property (@(posedge clk) disable iff (rst) $rose(arb_lost) |-> (!busy && tx_bit)); // R8
    AST_LOST_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(arb_lost) |-> ($past(tx_bit) && !$past(rx_bit) && $past(bit_en))); // R8
    AST_LOST_NO_DONE: assert property (@(posedge clk) disable iff (rst) done |-> !arb_lost); // R9
endmodule

bind can_arb_tx can_arb_tx_chk u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .start(start), .rx_bit(rx_bit),
    .tx_bit(tx_bit), .busy(busy), .arb_lost(arb_lost), .done(done)
);

// File: tb/sim_can_arb_tx.sv
module sim_can_arb_tx;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        start = 1'b0;
    logic        other = 1'b1;
    logic [10:0] id = '0;
    logic [3:0]  dlc = '0;
    logic [63:0] data = '0;
    logic        rx_bit;
    logic        tx_bit, busy, arb_lost, done;

    int vectors = 0;
    int fails = 0;

    logic t_s [0:255];
    logic t_a [0:255];
    int   t_k [0:255];
    int   t_n;
    int   st_run;
    logic st_last;
    logic a_s [0:255];
    logic a_a [0:255];
    int   a_k [0:255];
    int   a_n;
    logic b_s [0:255];
    logic b_a [0:255];
    int   b_n;

    assign rx_bit = tx_bit & other;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_arb_tx u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .start(start), .id(id), .dlc(dlc),
        .data(data), .rx_bit(rx_bit), .tx_bit(tx_bit), .busy(busy),
        .arb_lost(arb_lost), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic b, input logic arb, input int kind);
        t_s[t_n] = b;
        t_a[t_n] = arb;
        t_k[t_n] = kind;
        t_n++;
        if (b == st_last) st_run++;
        else st_run = 1;
        st_last = b;
    endtask

    // reference frame: kind 0 header, 1 checksum, 2 stuff, 3 tail
    task automatic build(input logic [10:0] fid, input logic [3:0] fdlc, input logic [63:0] fdata);
        logic        u [0:127];
        int          nu;
        int          nh;
        int          nby;
        logic [14:0] crc;
        logic        fb;
        nu = 0;
        u[nu] = 1'b0; nu++;
        for (int i = 10; i >= 0; i--) begin u[nu] = fid[i]; nu++; end
        for (int i = 0; i < 3; i++) begin u[nu] = 1'b0; nu++; end
        for (int i = 3; i >= 0; i--) begin u[nu] = fdlc[i]; nu++; end
        nby = (fdlc > 4'd8) ? 8 : int'(fdlc);
        for (int b = 0; b < nby; b++)
            for (int j = 7; j >= 0; j--) begin u[nu] = fdata[8*b+j]; nu++; end
        crc = '0;
        for (int i = 0; i < nu; i++) begin
            fb  = u[i] ^ crc[14];
            crc = {crc[13:0], 1'b0};
            if (fb) crc = crc ^ 15'h4599;
        end
        nh = nu;
        for (int i = 14; i >= 0; i--) begin u[nu] = crc[i]; nu++; end
        t_n = 0; st_run = 0; st_last = 1'b1;
        for (int i = 0; i < nu; i++) begin
            put(u[i], (i >= 1 && i <= 12), (i < nh) ? 0 : 1);
            if (st_run == 5) put(!u[i], 1'b0, 2);
        end
        for (int i = 0; i < 10; i++) put(1'b1, 1'b0, 3);
    endtask

    function automatic string tag(input int k, input string h);
        case (k)
            0:       return h;
            1:       return "R5";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic pulse();
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
    endtask

    task automatic run_frame(input logic [10:0] oid, input logic [3:0] odlc, input logic [63:0] odata,
                             input bit comp, input logic [10:0] cid, input logic [3:0] cdlc,
                             input logic [63:0] cdata, input bit ack, input bit poke, input string htag);
        int L;
        bit oact;
        b_n = 0;
        if (comp) begin
            build(cid, cdlc, cdata);
            for (int i = 0; i < t_n; i++) begin b_s[i] = t_s[i]; b_a[i] = t_a[i]; end
            b_n = t_n;
        end
        build(oid, odlc, odata);
        for (int i = 0; i < t_n; i++) begin a_s[i] = t_s[i]; a_a[i] = t_a[i]; a_k[i] = t_k[i]; end
        a_n = t_n;
        L = -1;
        if (comp) begin
            for (int i = 0; i < a_n && i < b_n; i++) begin
                if (a_s[i] != b_s[i]) begin
                    if (a_a[i] && a_s[i]) L = i;
                    break;
                end
            end
        end
        @(negedge clk);
        id = oid; dlc = odlc; data = odata; start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        chk("R8 arb_lost cleared by start", int'(arb_lost), 0);
        oact = comp;
        for (int i = 0; i < 400; i++) begin
            pulse();
            if (L >= 0 && i == L + 1) begin
                chk("R8 busy after loss", int'(busy), 0);
                chk("R8 arb_lost after loss", int'(arb_lost), 1);
                chk("R8 tx released", int'(tx_bit), 1);
                for (int j = 0; j < 3; j++) begin
                    pulse();
                    chk("R8 tx stays recessive", int'(tx_bit), 1);
                    chk("R8 arb_lost held", int'(arb_lost), 1);
                    chk("R8 no done after loss", int'(done), 0);
                end
                break;
            end
            if (i == a_n) begin
                chk("R10 done at frame end", int'(done), 1);
                chk("R10 busy drops with done", int'(busy), 0);
                chk("R9 no arbitration loss", int'(arb_lost), 0);
                @(negedge clk);
                chk("R10 done one clock", int'(done), 0);
                break;
            end
            chk(tag(a_k[i], htag), int'(tx_bit), int'(a_s[i]));
            other = 1'b1;
            if (oact && i < b_n) begin
                other = b_s[i];
                if (b_a[i] && b_s[i] && !a_s[i]) oact = 1'b0;
            end else if (ack && i == a_n - 9) begin
                other = 1'b0;
            end
            if (poke && i == 20) begin
                id = ~oid; dlc = 4'd3; data = ~odata; start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
            repeat (BIT_CLKS - 2) @(negedge clk);
        end
        other = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [10:0] rid, cidr;
        logic [3:0]  rdlc, cdr;
        logic [63:0] rdat, cdat;
        bit          comp;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx idle", int'(tx_bit), 1);
        chk("R1 busy idle", int'(busy), 0);
        chk("R1 arb_lost idle", int'(arb_lost), 0);
        chk("R1 done idle", int'(done), 0);
        // long stuffing chains
        run_frame(11'h000, 4'd8, 64'h0, 1'b0, '0, '0, '0, 1'b1, 1'b0, "R3");
        run_frame(11'h7FF, 4'd8, {64{1'b1}}, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R3");
        run_frame(11'h2A5, 4'd0, 64'h0, 1'b0, '0, '0, '0, 1'b1, 1'b0, "R3");
        // length code above eight
        run_frame(11'h155, 4'd15, 64'h0123_4567_89AB_CDEF, 1'b0, '0, '0, '0, 1'b1, 1'b0, "R4");
        run_frame(11'h0F0, 4'd9, 64'hDEAD_BEEF_0BAD_F00D, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R4");
        // losing and winning arbitration on the last identifier bit
        run_frame(11'h123, 4'd2, 64'h55AA, 1'b1, 11'h122, 4'd2, 64'h55AA, 1'b0, 1'b0, "R3");
        run_frame(11'h122, 4'd2, 64'h55AA, 1'b1, 11'h123, 4'd2, 64'h55AA, 1'b1, 1'b0, "R9");
        // same identifier, payload differs: not an arbitration loss
        run_frame(11'h3C3, 4'd4, 64'hFFFF_FFFF, 1'b1, 11'h3C3, 4'd4, 64'h0, 1'b0, 1'b0, "R9");
        // start and input changes mid-frame ignored
        run_frame(11'h5A5, 4'd6, 64'h1122_3344_5566, 1'b0, '0, '0, '0, 1'b1, 1'b1, "R2");
        for (int n = 0; n < 40; n++) begin
            rid  = 11'($urandom);
            rdlc = 4'($urandom);
            rdat = {32'($urandom), 32'($urandom)};
            comp = ($urandom % 2) == 0;
            cidr = (($urandom % 4) == 0) ? rid : 11'($urandom);
            cdr  = 4'($urandom);
            cdat = {32'($urandom), 32'($urandom)};
            run_frame(rid, rdlc, rdat, comp, cidr, cdr, cdat, 1'b1, (n % 7) == 3, "R3");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule